// File: doc/BRIEF.md
# Branch Resolution Unit

This block is the execute step for the branch instructions of a 64-bit core. It takes one 32-bit instruction word, the address of that instruction, and the current condition, count and link register values. In the same cycle it decides whether the branch is taken and gives the next fetch address. It also gives the new count and link register values, each with a write enable. Two hint flags tell a return-address predictor whether the instruction is a call or a return.

Four branch forms are recognised:

- the unconditional immediate branch;
- the conditional displacement branch;
- the conditional branch through the link register;
- the conditional branch through the count register.

Any other encoding is reported as not a branch, and the block then leaves all state unchanged. The unit is purely combinational, so an outer pipeline can put it between any two register stages. It has no state machine: every output depends only on the current inputs.

Top module: `bru_resolve`

## Requirements
- R1: The primary opcode is insn[31:26]. Value 18 is the unconditional branch and 16 is the conditional displacement branch. With opcode 19, the extended field insn[10:1] selects the link-register branch (16) or the count-register branch (528). All other encodings raise `not_branch`.
- R2: The unconditional branch is always taken. Its byte offset is insn[25:2] followed by two zero bits, sign-extended from bit 25 to XLEN bits. When insn[1] is 1 the offset is the target itself; when insn[1] is 0 the target is `cia` plus the offset.
- R3: The conditional displacement branch has a byte offset of insn[15:2] followed by two zero bits, sign-extended from bit 15. insn[1] selects an absolute or `cia`-relative target in the same way as in R2.
- R4: The count test uses the control field insn[25:21], with bit 4 as the MSB. When its bit 2 is 1 the test passes and the count is left alone. Otherwise the count is reduced by one first. The test then passes when the reduced value is nonzero and control bit 1 is 0, or when it is zero and control bit 1 is 1. The displacement branch and the link-register branch are taken only if both the count test and the condition test pass.
- R5: The condition test passes when control bit 4 is 1. Otherwise it passes when `cr` bit (31 − S) equals control bit 3, where S = insn[20:16] and `cr` bit 0 is its LSB.
- R6: The count-register branch is taken on the condition test alone and never reduces the count.
- R7: The link-register branch targets `lr` with its two low bits cleared. The count-register branch targets `ctr` with its two low bits cleared. Both use the register values before any update by this instruction.
- R8: For any branch with insn[0] = 1, `lr_we` is 1 and `lr_next` = `cia` + 4, whether or not the branch is taken. Otherwise `lr_we` is 0 and `lr_next` equals `lr`.
- R9: `hint_call` equals `lr_we`. `hint_return` is 1 only for the link-register branch with insn[0] = 0. The two hints are never 1 together.
- R10: When `taken` is 0, `nia` = `cia` + 4.
- R11: `ctr_we` is 1 only when a count reduction happens, and then `ctr_next` = `ctr` − 1, wrapping from 0 to all ones. Otherwise `ctr_next` equals `ctr`.
- R12: For a non-branch encoding, all of these outputs are 0: `taken`, `ctr_we`, `lr_we`, `hint_call` and `hint_return`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| cia | input | XLEN | Address of the instruction |
| cr | input | CR_W | Condition register |
| ctr | input | XLEN | Count register |
| lr | input | XLEN | Link register |
| taken | output | 1 | Branch is taken |
| nia | output | XLEN | Next instruction address |
| ctr_we | output | 1 | Count register write enable |
| ctr_next | output | XLEN | New count register value |
| lr_we | output | 1 | Link register write enable |
| lr_next | output | XLEN | New link register value |
| hint_call | output | 1 | Predictor hint: subroutine call |
| hint_return | output | 1 | Predictor hint: subroutine return |
| not_branch | output | 1 | Encoding is not a handled branch |

## Verification
The bench builds the unit with the defaults XLEN = 64 and CR_W = 32.

With a 64-bit address path, sign extension of both offset widths can be checked all the way to bit 63. It also lets the bench check that relative targets wrap around the top of the address space. A 64-bit count makes the wrap from zero to all ones a visible corner case.

A 32-bit condition register lets the 5-bit selector reach every register bit, including both ends (selector 0 reads the MSB, selector 31 reads the LSB).

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int INSN_W = 32;

    localparam logic [5:0] OP_IMM  = 6'd18;
    localparam logic [5:0] OP_DISP = 6'd16;
    localparam logic [5:0] OP_XL   = 6'd19;
    localparam logic [9:0] XO_LR   = 10'd16;
    localparam logic [9:0] XO_CTR  = 10'd528;

    typedef enum logic [2:0] {
        BRK_NONE = 3'd0,
        BRK_IMM  = 3'd1,
        BRK_DISP = 3'd2,
        BRK_LR   = 3'd3,
        BRK_CTR  = 3'd4
    } brk_e;

    typedef struct packed {
        brk_e        kind;
        logic        abs_mode;
        logic        link;
        logic [4:0]  ctl;
        logic [4:0]  sel;
        logic [23:0] imm_fld;
        logic [13:0] disp_fld;
    } bru_fields_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output bru_fields_t       fld
);
    logic [5:0] opc;
    logic [9:0] xop;

    assign opc = insn[31:26];
    assign xop = insn[10:1];

    always_comb begin
        fld.kind = BRK_NONE;
        unique case (opc)
            OP_IMM:  fld.kind = BRK_IMM;
            OP_DISP: fld.kind = BRK_DISP;
            OP_XL: begin
                if (xop == XO_LR)
                    fld.kind = BRK_LR;
                else if (xop == XO_CTR)
                    fld.kind = BRK_CTR;
                else
                    fld.kind = BRK_NONE;
            end
            default: fld.kind = BRK_NONE;
        endcase
        fld.abs_mode = insn[1];
        fld.link     = insn[0];
        fld.ctl      = insn[25:21];
        fld.sel      = insn[20:16];
        fld.imm_fld  = insn[25:2];
        fld.disp_fld = insn[15:2];
    end

    // R1: a register-target kind only comes from the opcode shared with other ops
    always_comb begin
        a_r1_xl_kinds: assert (!(fld.kind == BRK_LR || fld.kind == BRK_CTR) || opc == OP_XL);
    end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CR_W = 32
) (
    input  brk_e            kind,
    input  logic [4:0]      ctl,
    input  logic [4:0]      sel,
    input  logic [CR_W-1:0] cr,
    input  logic [XLEN-1:0] ctr,
    output logic            dec_en,
    output logic [XLEN-1:0] ctr_dec,
    output logic            go
);
    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(CR_W - 1);

    logic             uses_count;
    logic             count_ok;
    logic             cond_ok;
    logic [SEL_W-1:0] bit_idx;

    assign uses_count = (kind == BRK_DISP) || (kind == BRK_LR);
    assign dec_en     = uses_count && !ctl[2];
    assign ctr_dec    = ctr - XLEN'(1);
    assign count_ok   = ctl[2] || ((ctr_dec != '0) ^ ctl[1]);
    assign bit_idx    = TOP_IDX - sel;
    assign cond_ok    = ctl[4] || (cr[bit_idx] == ctl[3]);

    always_comb begin
        unique case (kind)
            BRK_IMM:         go = 1'b1;
            BRK_DISP, BRK_LR: go = count_ok && cond_ok;
            BRK_CTR:         go = cond_ok;
            default:         go = 1'b0;
        endcase
    end

    always_comb begin
        // R6: the count-register branch never reduces the count
        a_r6_no_dec_on_ctr: assert (!(kind == BRK_CTR && dec_en));
        // R12: nothing is taken for a non-branch
        a_r12_none_idle: assert (!(kind == BRK_NONE && (go || dec_en)));
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  brk_e            kind,
    input  logic            abs_mode,
    input  logic [23:0]     imm_fld,
    input  logic [13:0]     disp_fld,
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] lr,
    input  logic [XLEN-1:0] ctr,
    output logic [XLEN-1:0] tgt
);
    localparam int IMM_OFF_W  = 26;
    localparam int DISP_OFF_W = 16;
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic [XLEN-1:0] imm_off;
    logic [XLEN-1:0] disp_off;
    logic [XLEN-1:0] off;

    assign imm_off  = {{(XLEN-IMM_OFF_W){imm_fld[23]}},  imm_fld,  2'b00};
    assign disp_off = {{(XLEN-DISP_OFF_W){disp_fld[13]}}, disp_fld, 2'b00};
    assign off      = (kind == BRK_IMM) ? imm_off : disp_off;

    always_comb begin
        unique case (kind)
            BRK_IMM, BRK_DISP: tgt = abs_mode ? off : (cia + off);
            BRK_LR:            tgt = lr & ALIGN_MASK;
            BRK_CTR:           tgt = ctr & ALIGN_MASK;
            default:           tgt = '0;
        endcase
    end

    always_comb begin
        // R7: register targets are word aligned
        a_r7_reg_aligned: assert (!(kind == BRK_LR || kind == BRK_CTR) || tgt[1:0] == 2'b00);
    end
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
    import bru_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CR_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   cia,
    input  logic [CR_W-1:0]   cr,
    input  logic [XLEN-1:0]   ctr,
    input  logic [XLEN-1:0]   lr,
    output logic              taken,
    output logic [XLEN-1:0]   nia,
    output logic              ctr_we,
    output logic [XLEN-1:0]   ctr_next,
    output logic              lr_we,
    output logic [XLEN-1:0]   lr_next,
    output logic              hint_call,
    output logic              hint_return,
    output logic              not_branch
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    bru_fields_t     fld;
    logic            dec_en;
    logic [XLEN-1:0] ctr_dec;
    logic            go;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq_pc;

    bru_decode u_dec (
        .insn (insn),
        .fld  (fld)
    );

    bru_cond #(.XLEN(XLEN), .CR_W(CR_W)) u_cond (
        .kind    (fld.kind),
        .ctl     (fld.ctl),
        .sel     (fld.sel),
        .cr      (cr),
        .ctr     (ctr),
        .dec_en  (dec_en),
        .ctr_dec (ctr_dec),
        .go      (go)
    );

    bru_target #(.XLEN(XLEN)) u_tgt (
        .kind     (fld.kind),
        .abs_mode (fld.abs_mode),
        .imm_fld  (fld.imm_fld),
        .disp_fld (fld.disp_fld),
        .cia      (cia),
        .lr       (lr),
        .ctr      (ctr),
        .tgt      (tgt)
    );

    assign seq_pc = cia + STEP;

    always_comb begin
        not_branch  = (fld.kind == BRK_NONE);
        taken       = go;
        nia         = go ? tgt : seq_pc;
        ctr_we      = dec_en;
        ctr_next    = dec_en ? ctr_dec : ctr;
        lr_we       = !not_branch && fld.link;
        lr_next     = lr_we ? seq_pc : lr;
        hint_call   = lr_we;
        hint_return = (fld.kind == BRK_LR) && !fld.link;
    end

    always_comb begin
        a_r9_hint_excl: assert (!(hint_call && hint_return));
        a_r10_fallthrough: assert (taken || nia == cia + STEP);
        a_r11_ctr_step: assert (!ctr_we || ctr_next == ctr - XLEN'(1));
        a_r8_link_value: assert (!lr_we || lr_next == cia + STEP);
        a_r12_quiet: assert (!not_branch || !(taken || ctr_we || lr_we || hint_call || hint_return));
    end
endmodule

// File: tb/tb_bru_resolve.sv
module tb_bru_resolve;

    localparam int XLEN = 64;
    localparam int CR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0]     insn = '0;
    logic [XLEN-1:0] cia = '0, ctr = '0, lr = '0;
    logic [CR_W-1:0] cr = '0;
    logic            taken, ctr_we, lr_we, hint_call, hint_return, not_branch;
    logic [XLEN-1:0] nia, ctr_next, lr_next;

    int nchk = 0;
    int nfail = 0;

    bru_resolve #(.XLEN(XLEN), .CR_W(CR_W)) dut (
        .insn(insn), .cia(cia), .cr(cr), .ctr(ctr), .lr(lr),
        .taken(taken), .nia(nia), .ctr_we(ctr_we), .ctr_next(ctr_next),
        .lr_we(lr_we), .lr_next(lr_next), .hint_call(hint_call),
        .hint_return(hint_return), .not_branch(not_branch)
    );

    typedef struct {
        logic            tk;
        logic [XLEN-1:0] na;
        logic            cwe;
        logic [XLEN-1:0] cnx;
        logic            lwe;
        logic [XLEN-1:0] lnx;
        logic            hc;
        logic            hr;
        logic            nb;
    } exp_t;

    function automatic exp_t model(logic [31:0] w, logic [XLEN-1:0] pc,
                                   logic [CR_W-1:0] c, logic [XLEN-1:0] n,
                                   logic [XLEN-1:0] l);
        exp_t e;
        int   k;
        logic [XLEN-1:0] off, tg, nd;
        logic [4:0] bo, bi;
        logic cnt_ok, cr_ok, dec;
        // kind: 0 none, 1 imm, 2 disp, 3 via lr, 4 via ctr
        k = 0;
        if (w[31:26] == 6'd18) k = 1;
        else if (w[31:26] == 6'd16) k = 2;
        else if (w[31:26] == 6'd19 && w[10:1] == 10'd16) k = 3;
        else if (w[31:26] == 6'd19 && w[10:1] == 10'd528) k = 4;
        bo = w[25:21];
        bi = w[20:16];
        dec = (k == 2 || k == 3) && (bo[2] == 1'b0);
        nd = n - 1;
        if (!dec || k == 4) cnt_ok = 1'b1;
        else cnt_ok = bo[1] ? (nd == 0) : (nd != 0);
        cr_ok = bo[4] ? 1'b1 : (((c >> (31 - bi)) & 1) == {31'b0, bo[3]});
        if (k == 1) off = {{38{w[25]}}, w[25:2], 2'b00};
        else off = {{48{w[15]}}, w[15:2], 2'b00};
        if (k == 3) tg = {l[XLEN-1:2], 2'b00};
        else if (k == 4) tg = {n[XLEN-1:2], 2'b00};
        else tg = w[1] ? off : pc + off;
        e.nb  = (k == 0);
        e.tk  = (k == 1) || ((k == 2 || k == 3) && cnt_ok && cr_ok) || (k == 4 && cr_ok);
        e.na  = e.tk ? tg : pc + 4;
        e.cwe = dec;
        e.cnx = dec ? nd : n;
        e.lwe = (k != 0) && w[0];
        e.lnx = e.lwe ? pc + 4 : l;
        e.hc  = e.lwe;
        e.hr  = (k == 3) && !w[0];
        return e;
    endfunction

    task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(string tag, logic [31:0] w, logic [XLEN-1:0] pc,
                         logic [CR_W-1:0] c, logic [XLEN-1:0] n, logic [XLEN-1:0] l);
        exp_t e;
        @(posedge clk);
        insn = w; cia = pc; cr = c; ctr = n; lr = l;
        e = model(w, pc, c, n, l);
        @(negedge clk);
        chk({tag, "/R1 not_branch"}, XLEN'(not_branch), XLEN'(e.nb));
        chk({tag, " taken"}, XLEN'(taken), XLEN'(e.tk));
        chk(e.tk ? {tag, " nia"} : {tag, "/R10 nia"}, nia, e.na);
        chk({tag, "/R11 ctr_we"}, XLEN'(ctr_we), XLEN'(e.cwe));
        chk({tag, "/R11 ctr_next"}, ctr_next, e.cnx);
        chk({tag, "/R8 lr_we"}, XLEN'(lr_we), XLEN'(e.lwe));
        chk({tag, "/R8 lr_next"}, lr_next, e.lnx);
        chk({tag, "/R9 hint_call"}, XLEN'(hint_call), XLEN'(e.hc));
        chk({tag, "/R9 hint_return"}, XLEN'(hint_return), XLEN'(e.hr));
    endtask

    function automatic logic [31:0] mk_b(logic [23:0] li, logic aa, logic lk);
        return {6'd18, li, aa, lk};
    endfunction
    function automatic logic [31:0] mk_bc(logic [4:0] bo, logic [4:0] bi, logic [13:0] bd,
                                          logic aa, logic lk);
        return {6'd16, bo, bi, bd, aa, lk};
    endfunction
    function automatic logic [31:0] mk_xl(logic [4:0] bo, logic [4:0] bi, logic [9:0] xo, logic lk);
        return {6'd19, bo, bi, 5'd0, xo, lk};
    endfunction

    initial begin
        #(8 * 200000);
        nfail++;
        nchk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] pc, n, l;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle encoding after reset: all-zero word is not a branch
        apply("R12 idle", 32'h0, 64'h1000, 32'h0, 64'h5, 64'h80);
        apply("R12 other-op19", mk_xl(5'b10100, 5'd0, 10'd33, 1'b1), 64'h2000, '1, 64'h9, 64'h44);
        // unconditional relative, negative offset
        apply("R2 b-back", mk_b(24'hFFFFF0, 1'b0, 1'b0), 64'h10000, '0, 64'h3, 64'h0);
        // unconditional absolute negative, with link
        apply("R2 ba-neg", mk_b(24'h800001, 1'b1, 1'b1), 64'h400, '0, 64'h3, 64'h77);
        // relative wrap past top of address space
        apply("R2 wrap", mk_b(24'h000010, 1'b0, 1'b0), 64'hFFFF_FFFF_FFFF_FFF0, '0, 0, 0);
        apply("R3 bc-abs", mk_bc(5'b10100, 5'd0, 14'h2001, 1'b1, 1'b0), 64'h800, '0, 64'h1, 0);
        apply("R3 bc-rel", mk_bc(5'b10100, 5'd0, 14'h0004, 1'b0, 1'b0), 64'h800, '0, 64'h1, 0);
        // count reaches zero, taken on zero
        apply("R4 zero-take", mk_bc(5'b10010, 5'd0, 14'h10, 1'b0, 1'b0), 64'h100, '0, 64'h1, 0);
        // count reaches zero, not taken on nonzero test
        apply("R4 zero-skip", mk_bc(5'b10000, 5'd0, 14'h10, 1'b0, 1'b1), 64'h100, '0, 64'h1, 0);
        // count wraps from zero
        apply("R11 wrap", mk_bc(5'b10000, 5'd0, 14'h10, 1'b0, 1'b0), 64'h100, '0, 64'h0, 0);
        // condition selector ends
        apply("R5 sel0", mk_bc(5'b01100, 5'd0, 14'h8, 1'b0, 1'b0), 64'h300, 32'h8000_0000, 7, 0);
        apply("R5 sel31", mk_bc(5'b01100, 5'd31, 14'h8, 1'b0, 1'b0), 64'h300, 32'h8000_0000, 7, 0);
        apply("R5 sel31-one", mk_bc(5'b00100, 5'd31, 14'h8, 1'b0, 1'b0), 64'h300, 32'h0000_0001, 7, 0);
        // count-register branch: no decrement even with control bit 2 clear
        apply("R6 via-ctr", mk_xl(5'b00000, 5'd3, 10'd528, 1'b0), 64'h500, 32'h0, 64'h1237, 64'h9);
        apply("R7 via-lr-call", mk_xl(5'b10100, 5'd0, 10'd16, 1'b1), 64'h600, '0, 64'h4, 64'hABCF);
        apply("R9 via-lr-ret", mk_xl(5'b10100, 5'd0, 10'd16, 1'b0), 64'h600, '0, 64'h4, 64'hABCE);
        apply("R8 link-not-taken", mk_bc(5'b00100, 5'd2, 14'h40, 1'b0, 1'b1), 64'h700, '1, 64'h4, 64'h1);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = int'($urandom % 8);
            case (sel)
                0: w[31:26] = 6'd18;
                1, 2: w[31:26] = 6'd16;
                3: begin w[31:26] = 6'd19; w[10:1] = 10'd16; end
                4: begin w[31:26] = 6'd19; w[10:1] = 10'd528; end
                5: w[31:26] = 6'd19;
                default: ;
            endcase
            pc = {$urandom, $urandom};
            l  = {$urandom, $urandom};
            n  = ($urandom % 2 == 0) ? XLEN'($urandom % 3) : {$urandom, $urandom};
            apply("R4 rnd", w, pc, $urandom, n, l);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule